// File: doc/BRIEF.md
# Associative Abstract Array with Bottom Values

This block is a small, fully associative memory that stands in for a much larger addressable array. It has a handful of rows. Each row keeps an address tag, a data word and a flag that says whether the word is a real value. Every address and data value at the interface travels with a validity bit. A cleared validity bit denotes the "bottom" value, which means unknown. Bottom propagates: reading an address that no row covers gives bottom, and so does reading with an address that is itself bottom.

The tags are loaded after reset through a configuration port, one row at a time. Asserting the done strobe then opens the array for requests. From that point the tags are frozen. One read port and one write port work in parallel. A read looks up the current contents combinationally. A write lands at the clock edge, so a read in the same cycle still sees the old contents.

A write whose address is bottom poisons every row. A write to an address that no row covers changes nothing. When two rows carry the same tag, the lower-numbered row serves both ports.

Top module: `aab_array`

## Requirements
- R1: After reset `ready` is 0. While `ready` is 0, every read returns bottom and every write is ignored.
- R2: While `ready` is 0, `cfg_en` loads `cfg_tag` into row `cfg_row`. `cfg_done` raises `ready` at the next clock edge. Configuration strobes are ignored once `ready` is 1.
- R3: A read with a valid address equal to a row tag returns that row's stored word and that row's validity flag, in the same cycle.
- R4: A read with a valid address that equals no row tag returns bottom (`rd_data_ok` = 0).
- R5: A read whose address validity bit is 0 returns bottom, even if the address bits equal a tag.
- R6: A write with a valid, matching address and valid data stores the data and sets the row's flag. The new value is readable from the next cycle; a read in the write cycle returns the previous contents.
- R7: A write with a valid, matching address and bottom data (`wr_data_ok` = 0) makes that row read as bottom afterwards.
- R8: A write with a valid address that matches no tag leaves every row unchanged.
- R9: A write whose address validity bit is 0 sets every row to bottom.
- R10: When several rows share a tag, the lowest-numbered of them is the row that both reads and writes use.
- R11: Writes never alter the tags; after a poisoning write, writes to configured addresses still reach their rows.
- R12: Whenever `rd_data_ok` is 0, `rd_data` is driven to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Load a tag into one row (before ready) |
| cfg_row | input | RIW | Row that receives the tag |
| cfg_tag | input | AW | Tag value |
| cfg_done | input | 1 | Ends configuration, raises ready |
| ready | output | 1 | Array accepts requests |
| rd_addr | input | AW | Read address |
| rd_addr_ok | input | 1 | Read address validity bit |
| rd_data | output | DW | Read data word |
| rd_data_ok | output | 1 | Read data validity bit (0 = bottom) |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_addr_ok | input | 1 | Write address validity bit |
| wr_data | input | DW | Write data word |
| wr_data_ok | input | 1 | Write data validity bit |

## Verification
The assertions assume a synchronous reset of at least one cycle before any traffic. They also assume configuration happens only before `ready` rises. The bench configures each row exactly once, pulses `cfg_done` and only then issues reads and writes. It gives every row a distinct tag, except for one deliberate duplicate pair that exercises priority. Every input changes on the falling edge, so each request is stable across the edge that commits it.

// File: rtl/aab_pkg.sv
package aab_pkg;

  localparam int MAX_ROWS = 32;

  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_STORE  = 2'd1,
    WR_MISS   = 2'd2,
    WR_POISON = 2'd3
  } wr_kind_e;

  // lowest set bit position; 0 when none set
  function automatic int unsigned first_set(input logic [MAX_ROWS-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = MAX_ROWS - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  function automatic wr_kind_e classify_write(input logic en, input logic addr_ok,
                                              input logic hit);
    if (!en)           return WR_IDLE;
    else if (!addr_ok) return WR_POISON;
    else if (hit)      return WR_STORE;
    else               return WR_MISS;
  endfunction

endpackage

// File: rtl/aab_match.sv
module aab_match #(
  parameter int ROWS = 4,
  parameter int AW   = 16,
  localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [AW-1:0]      addr,
  input  logic               addr_ok,
  input  logic [ROWS*AW-1:0] tag_flat,
  output logic               hit,
  output logic [RIW-1:0]     idx
);
  logic [ROWS-1:0] eq;

  for (genvar i = 0; i < ROWS; i++) begin : g_cmp
    assign eq[i] = addr_ok && (tag_flat[i*AW +: AW] == addr);
  end

  assign hit = |eq;
  assign idx = RIW'(aab_pkg::first_set(aab_pkg::MAX_ROWS'(eq)));
endmodule

// File: rtl/aab_row.sv
module aab_row #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_tag,
  input  logic          store,
  input  logic          poison,
  input  logic [DW-1:0] wdata,
  input  logic          wdata_ok,
  output logic [AW-1:0] tag,
  output logic [DW-1:0] data,
  output logic          ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag  <= '0;
      data <= '0;
      ok   <= 1'b0;
    end else begin
      if (cfg_we) tag <= cfg_tag;
      if (poison) begin
        data <= '0;
        ok   <= 1'b0;
      end else if (store) begin
        data <= wdata_ok ? wdata : '0;
        ok   <= wdata_ok;
      end
    end
  end
endmodule

// File: rtl/aab_array.sv
module aab_array #(
  parameter int ROWS = 4,
  parameter int AW   = 16,
  parameter int DW   = 8,
  localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic [RIW-1:0] cfg_row,
  input  logic [AW-1:0]  cfg_tag,
  input  logic           cfg_done,
  output logic           ready,
  input  logic [AW-1:0]  rd_addr,
  input  logic           rd_addr_ok,
  output logic [DW-1:0]  rd_data,
  output logic           rd_data_ok,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic           wr_addr_ok,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_data_ok
);
  import aab_pkg::*;

  logic [ROWS*AW-1:0] tag_flat;
  logic [ROWS*DW-1:0] data_flat;
  logic [ROWS-1:0]    row_ok_vec;
  logic               rd_hit, wr_hit;
  logic [RIW-1:0]     rd_idx, wr_idx;
  wr_kind_e           wr_kind;
  logic               cfg_go;

  assign cfg_go = cfg_en && !ready;

  always_ff @(posedge clk) begin
    if (rst)                    ready <= 1'b0;
    else if (cfg_done && !ready) ready <= 1'b1;
  end

  aab_match #(.ROWS(ROWS), .AW(AW)) u_rd_match (
    .addr(rd_addr), .addr_ok(rd_addr_ok), .tag_flat(tag_flat),
    .hit(rd_hit), .idx(rd_idx)
  );

  aab_match #(.ROWS(ROWS), .AW(AW)) u_wr_match (
    .addr(wr_addr), .addr_ok(wr_addr_ok), .tag_flat(tag_flat),
    .hit(wr_hit), .idx(wr_idx)
  );

  assign wr_kind = classify_write(wr_en && ready, wr_addr_ok, wr_hit);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic store_i;
    assign store_i = (wr_kind == WR_STORE) && (wr_idx == RIW'(i));
    aab_row #(.AW(AW), .DW(DW)) u_row (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_go && (cfg_row == RIW'(i))),
      .cfg_tag(cfg_tag),
      .store(store_i),
      .poison(wr_kind == WR_POISON),
      .wdata(wr_data), .wdata_ok(wr_data_ok),
      .tag(tag_flat[i*AW +: AW]),
      .data(data_flat[i*DW +: DW]),
      .ok(row_ok_vec[i])
    );
  end

  assign rd_data_ok = ready && rd_hit && row_ok_vec[rd_idx];
  assign rd_data    = rd_data_ok ? data_flat[rd_idx*DW +: DW] : '0;

endmodule

// File: rtl/aab_array_chk.sv
module aab_array_chk #(
  parameter int ROWS = 4,
  parameter int AW   = 16,
  parameter int DW   = 8,
  localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               ready,
  input logic               rd_addr_ok,
  input logic [DW-1:0]      rd_data,
  input logic               rd_data_ok,
  input logic               wr_data_ok,
  input aab_pkg::wr_kind_e  wr_kind,
  input logic [RIW-1:0]     wr_idx,
  input logic [ROWS*AW-1:0] tag_flat,
  input logic [ROWS*DW-1:0] data_flat,
  input logic [ROWS-1:0]    row_ok_vec
);
  import aab_pkg::*;

  a_r1_idle_bottom: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !rd_data_ok);

  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(row_ok_vec) && $stable(data_flat));

  a_r5_bad_addr: assert property (@(posedge clk) disable iff (rst)
    !rd_addr_ok |-> !rd_data_ok);

  a_r6_store_valid: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WR_STORE) && wr_data_ok |=> row_ok_vec[$past(wr_idx)]);

  a_r7_store_bottom: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WR_STORE) && !wr_data_ok |=> !row_ok_vec[$past(wr_idx)]);

  a_r8_miss_stable: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WR_MISS) |=> $stable(row_ok_vec) && $stable(data_flat));

  a_r9_poison_all: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WR_POISON) |=> (row_ok_vec == '0));

  a_r11_tags_frozen: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(tag_flat));

  a_r12_bottom_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_data_ok |-> (rd_data == '0));

endmodule

bind aab_array aab_array_chk #(.ROWS(ROWS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .rd_addr_ok(rd_addr_ok),
  .rd_data(rd_data), .rd_data_ok(rd_data_ok), .wr_data_ok(wr_data_ok),
  .wr_kind(wr_kind), .wr_idx(wr_idx), .tag_flat(tag_flat),
  .data_flat(data_flat), .row_ok_vec(row_ok_vec)
);

// File: tb/aab_array_test.sv
module aab_array_test;
  localparam int ROWS = 4;
  localparam int AW   = 16;
  localparam int DW   = 8;
  localparam int RIW  = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_en = 1'b0, cfg_done = 1'b0;
  logic [RIW-1:0] cfg_row = '0;
  logic [AW-1:0]  cfg_tag = '0;
  logic           ready;
  logic [AW-1:0]  rd_addr = '0;
  logic           rd_addr_ok = 1'b0;
  logic [DW-1:0]  rd_data;
  logic           rd_data_ok;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic           wr_addr_ok = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic           wr_data_ok = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  aab_array #(.ROWS(ROWS), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_row(cfg_row), .cfg_tag(cfg_tag),
    .cfg_done(cfg_done), .ready(ready), .rd_addr(rd_addr), .rd_addr_ok(rd_addr_ok),
    .rd_data(rd_data), .rd_data_ok(rd_data_ok), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_addr_ok(wr_addr_ok), .wr_data(wr_data), .wr_data_ok(wr_data_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read at current time (inputs driven after a falling edge), compare both outputs
  task automatic read_chk(input string req, input logic [AW-1:0] a, input logic aok,
                          input logic eok, input logic [DW-1:0] edata);
    rd_addr = a; rd_addr_ok = aok;
    #1;
    check({req, " ok"},   32'(rd_data_ok), 32'(eok));
    check({req, " data"}, 32'(rd_data),    eok ? 32'(edata) : 32'h0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic aok,
                          input logic [DW-1:0] d, input logic dok);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_addr_ok = aok; wr_data = d; wr_data_ok = dok;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready after reset", 32'(ready), 32'h0);
    read_chk("R1 read before ready", 16'h0000, 1'b1, 1'b0, 8'h00);
    do_write(16'h0000, 1'b1, 8'h5A, 1'b1);
    read_chk("R1 write before ready ignored", 16'h0000, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic cfg_one(input int r, input logic [AW-1:0] t);
    @(negedge clk);
    cfg_en = 1'b1; cfg_row = RIW'(r); cfg_tag = t;
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic t_config;
    cfg_one(0, 16'h0100);
    cfg_one(1, 16'h0200);
    cfg_one(2, 16'h0300);
    cfg_one(3, 16'h0200);   // duplicate of row 1 for R10
    check("R2 not ready before done", 32'(ready), 32'h0);
    @(negedge clk); cfg_done = 1'b1;
    @(negedge clk); cfg_done = 1'b0;
    check("R2 ready after done", 32'(ready), 32'h1);
    read_chk("R1 pre-ready write left no value", 16'h0100, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_write_read;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h0100; wr_addr_ok = 1'b1; wr_data = 8'hA5; wr_data_ok = 1'b1;
    read_chk("R6 same-cycle read sees old", 16'h0100, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
    read_chk("R3 R6 read after write", 16'h0100, 1'b1, 1'b1, 8'hA5);
    do_write(16'h0300, 1'b1, 8'h33, 1'b1);
    read_chk("R3 second row", 16'h0300, 1'b1, 1'b1, 8'h33);
    read_chk("R3 first row intact", 16'h0100, 1'b1, 1'b1, 8'hA5);
  endtask

  task automatic t_miss;
    read_chk("R4 unmatched read", 16'h0400, 1'b1, 1'b0, 8'h00);
    do_write(16'h0400, 1'b1, 8'hEE, 1'b1);
    read_chk("R8 miss write row0", 16'h0100, 1'b1, 1'b1, 8'hA5);
    read_chk("R8 miss write row2", 16'h0300, 1'b1, 1'b1, 8'h33);
    read_chk("R8 miss write stays miss", 16'h0400, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_bad_addr;
    read_chk("R5 bottom read address", 16'h0100, 1'b0, 1'b0, 8'h00);
    read_chk("R12 bottom data is zero", 16'h0300, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_bottom_data;
    do_write(16'h0300, 1'b1, 8'hC3, 1'b0);
    read_chk("R7 bottom data stored", 16'h0300, 1'b1, 1'b0, 8'h00);
    read_chk("R7 other row kept", 16'h0100, 1'b1, 1'b1, 8'hA5);
  endtask

  task automatic t_dup;
    do_write(16'h0200, 1'b1, 8'h22, 1'b1);
    read_chk("R10 duplicate tag lowest row", 16'h0200, 1'b1, 1'b1, 8'h22);
    do_write(16'h0200, 1'b1, 8'h23, 1'b1);
    read_chk("R10 duplicate tag rewrite", 16'h0200, 1'b1, 1'b1, 8'h23);
  endtask

  task automatic t_poison;
    do_write(16'h0100, 1'b0, 8'h11, 1'b1);
    read_chk("R9 poison row0", 16'h0100, 1'b1, 1'b0, 8'h00);
    read_chk("R9 poison row1", 16'h0200, 1'b1, 1'b0, 8'h00);
    read_chk("R9 poison row2", 16'h0300, 1'b1, 1'b0, 8'h00);
    do_write(16'h0100, 1'b1, 8'h77, 1'b1);
    read_chk("R11 tag kept after poison", 16'h0100, 1'b1, 1'b1, 8'h77);
  endtask

  task automatic t_cfg_locked;
    cfg_one(0, 16'h0500);
    do_write(16'h0500, 1'b1, 8'h55, 1'b1);
    read_chk("R2 late config ignored", 16'h0500, 1'b1, 1'b0, 8'h00);
    read_chk("R2 R11 original tag serves", 16'h0100, 1'b1, 1'b1, 8'h77);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_config;
    t_write_read;
    t_miss;
    t_bad_addr;
    t_bottom_data;
    t_dup;
    t_poison;
    t_cfg_locked;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule